// File: doc/BRIEF.md
# Inter-core doorbell mailbox

This block gives each processor core a doorbell word. Each bit is a separate doorbell, used to raise inter-processor interrupts. Any bus master can ring doorbells in any core's word by writing a mask to that core's ring address. The mask is ORed into the word.

The owning core reads its word through its acknowledge address. It then writes a mask back to the same address to drop the bits it has handled. While a core's word holds any set bit, the block drives a level request for that core. Enabling or masking that request toward the processor happens in a separate routing block.

The ring addresses form one window and the acknowledge addresses form another. Within each window, cores sit at a 16-byte stride. Several write ports are provided so that different masters can act in the same cycle. A sender that wants to reach several cores writes once to each core's ring address.

Top module: `mbox_doorbell`

## Requirements
- R1: After a synchronous active-low reset, every doorbell word is zero, every request is low and the read data is zero.
- R2: A write of mask M to byte address RING_BASE + 16·n sets the bits of M in core n's word (OR), visible from the next clock edge.
- R3: A write of mask M to byte address ACK_BASE + 16·n clears the bits that are one in M from core n's word; bits that are zero in M keep their value.
- R4: A read of ACK_BASE + 16·n, with rd_en high for one cycle, returns core n's word on rd_data after that clock edge. The value is the one before any write taking effect on the same edge. rd_data holds between reads.
- R5: A read of any ring address, or of any address outside the exact word addresses of the acknowledge window, returns zero.
- R6: req[n] is high exactly when core n's word is non-zero.
- R7: When a ring write and an acknowledge write reach the same word in the same cycle on different ports, the ring write wins for overlapping bits, and the remaining acknowledged bits are cleared.
- R8: Writes to any address other than the exact ring or acknowledge word addresses change no word. This includes offsets 4, 8 and 12 inside a core's 16-byte slot.
- R9: Ring writes from several ports to the same word in one cycle are ORed together, and a write to core n leaves every other core's word unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | NUM_WR | Write strobe per write port |
| wr_addr | input | NUM_WR×ADDR_W | Byte address per write port |
| wr_data | input | NUM_WR×BELL_W | Write mask per write port |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read byte address |
| rd_data | output | BELL_W | Registered read data |
| req | output | NUM_CORES | Level request per core, high while its word is non-zero |

## Verification
The bench uses four cores and two write ports, with the word width reduced to 8 bits. It keeps the default 8-bit address with the ring window at 0x80 and the acknowledge window at 0xC0. With these values, every one of the 256 addresses can be swept for both writes and reads. This shows that only the eight exact word addresses decode. Every single doorbell bit of every core is set and cleared in turn. Overlapping ring and acknowledge masks on the two ports cover the set-wins rule across a range of patterns.

// File: rtl/mbox_doorbell.sv
module mbox_doorbell #(
  parameter int NUM_CORES = 4,
  parameter int BELL_W    = 32,
  parameter int NUM_WR    = 2,
  parameter int ADDR_W    = 8,
  parameter int RING_BASE = 'h80,
  parameter int ACK_BASE  = 'hC0,
  parameter int STRIDE    = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_WR-1:0]              wr_en,
  input  logic [NUM_WR-1:0][ADDR_W-1:0]  wr_addr,
  input  logic [NUM_WR-1:0][BELL_W-1:0]  wr_data,
  input  logic                           rd_en,
  input  logic [ADDR_W-1:0]              rd_addr,
  output logic [BELL_W-1:0]              rd_data,
  output logic [NUM_CORES-1:0]           req
);

  function automatic logic [ADDR_W-1:0] slot(input int base, input int core);
    return ADDR_W'(base + STRIDE * core);
  endfunction

  logic [NUM_CORES-1:0][BELL_W-1:0] bells, ring_m, ack_m;
  logic [BELL_W-1:0]                rd_next;
  logic                             rd_hit;

  always_comb begin
    ring_m = '0;
    ack_m  = '0;
    for (int c = 0; c < NUM_CORES; c++)
      for (int p = 0; p < NUM_WR; p++) begin
        if (wr_en[p] && wr_addr[p] == slot(RING_BASE, c)) ring_m[c] |= wr_data[p];
        if (wr_en[p] && wr_addr[p] == slot(ACK_BASE, c))  ack_m[c]  |= wr_data[p];
      end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bells <= '0;
    else
      for (int c = 0; c < NUM_CORES; c++)
        bells[c] <= (bells[c] & ~ack_m[c]) | ring_m[c];
  end

  always_comb begin
    rd_next = '0;
    rd_hit  = 1'b0;
    for (int c = 0; c < NUM_CORES; c++)
      if (rd_addr == slot(ACK_BASE, c)) begin
        rd_next = bells[c];
        rd_hit  = 1'b1;
      end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_next;
  end

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    assign req[c] = |bells[c];

    // R2
    p_ring_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (|ring_m[c]) |=> ((bells[c] & $past(ring_m[c])) == $past(ring_m[c])));

    // R3 / R7
    p_ack_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (|ack_m[c]) |=> ((bells[c] & $past(ack_m[c] & ~ring_m[c])) == '0));

    // R8
    p_no_stray_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((bells[c] & ~$past(bells[c]) & ~$past(ring_m[c])) == '0));

    // R6
    p_req_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req[c]) |-> $past(|ring_m[c]));
  end

  // R5
  p_miss_reads_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_hit) |=> (rd_data == '0));

  // R4
  p_read_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

endmodule

// File: tb/mbox_doorbell_tb.sv
module mbox_doorbell_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 4;
  localparam int BW = 8;
  localparam int NW = 2;
  localparam int AW = 8;
  localparam int RB = 'h80;
  localparam int AB = 'hC0;

  logic                      clk = 0;
  logic                      rst_n;
  logic [NW-1:0]             wr_en;
  logic [NW-1:0][AW-1:0]     wr_addr;
  logic [NW-1:0][BW-1:0]     wr_data;
  logic                      rd_en;
  logic [AW-1:0]             rd_addr;
  logic [BW-1:0]             rd_data;
  logic [NC-1:0]             req;

  logic [BW-1:0] model [NC];
  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbox_doorbell #(.NUM_CORES(NC), .BELL_W(BW), .NUM_WR(NW), .ADDR_W(AW),
                  .RING_BASE(RB), .ACK_BASE(AB), .STRIDE(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .req(req));

  function automatic logic [AW-1:0] ring_a(input int c); return AW'(RB + 16*c); endfunction
  function automatic logic [AW-1:0] ack_a(input int c);  return AW'(AB + 16*c); endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] expv, input string tag);
    n_tests++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic req_chk(input string tag);
    logic [NC-1:0] e;
    for (int c = 0; c < NC; c++) e[c] = (model[c] != 0);
    chk(32'(req), 32'(e), tag);
  endtask

  task automatic model_apply(input logic e0, input logic [AW-1:0] a0, input logic [BW-1:0] d0,
                             input logic e1, input logic [AW-1:0] a1, input logic [BW-1:0] d1);
    for (int c = 0; c < NC; c++) begin
      logic [BW-1:0] s, k;
      s = '0; k = '0;
      if (e0 && a0 == ring_a(c)) s |= d0;
      if (e1 && a1 == ring_a(c)) s |= d1;
      if (e0 && a0 == ack_a(c))  k |= d0;
      if (e1 && a1 == ack_a(c))  k |= d1;
      model[c] = (model[c] & ~k) | s;
    end
  endtask

  task automatic wr2(input logic e0, input logic [AW-1:0] a0, input logic [BW-1:0] d0,
                     input logic e1, input logic [AW-1:0] a1, input logic [BW-1:0] d1);
    @(negedge clk);
    wr_en = {e1, e0};
    wr_addr[0] = a0; wr_data[0] = d0;
    wr_addr[1] = a1; wr_data[1] = d1;
    model_apply(e0, a0, d0, e1, a1, d1);
    @(posedge clk); #1;
    wr_en = '0;
  endtask

  task automatic rd_chk(input logic [AW-1:0] a, input logic [BW-1:0] expv, input string tag);
    @(negedge clk);
    rd_en = 1; rd_addr = a;
    @(posedge clk); #1;
    rd_en = 0;
    chk(32'(rd_data), 32'(expv), tag);
  endtask

  task automatic clear_all();
    for (int c = 0; c < NC; c++) wr2(1, ack_a(c), '1, 0, '0, '0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 0; wr_en = '0; wr_addr = '0; wr_data = '0; rd_en = 0; rd_addr = '0;
    for (int c = 0; c < NC; c++) model[c] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // R1: reset state
    chk(32'(req), 0, "R1 req after reset");
    chk(32'(rd_data), 0, "R1 rd_data after reset");
    for (int c = 0; c < NC; c++) rd_chk(ack_a(c), '0, "R1 word after reset");

    // R2 / R3 / R6: every single bit of every core
    for (int c = 0; c < NC; c++)
      for (int b = 0; b < BW; b++) begin
        wr2(1, ring_a(c), BW'(1) << b, 0, '0, '0);
        req_chk("R6 req after ring");
        rd_chk(ack_a(c), model[c], "R2 single bit ring");
      end
    for (int c = 0; c < NC; c++)
      for (int b = 0; b < BW; b++) begin
        wr2(1, ack_a(c), BW'(1) << b, 0, '0, '0);
        req_chk("R6 req after ack");
        rd_chk(ack_a(c), model[c], "R3 single bit ack");
      end
    chk(32'(req), 0, "R3 all acknowledged");

    // R3: partial clear keeps other bits
    wr2(1, ring_a(1), 8'hA5, 0, '0, '0);
    wr2(1, ack_a(1), 8'h0F, 0, '0, '0);
    rd_chk(ack_a(1), 8'hA0, "R3 partial ack");

    // R9: two ports ring same word, other cores untouched
    clear_all();
    wr2(1, ring_a(2), 8'h11, 1, ring_a(2), 8'h82);
    rd_chk(ack_a(2), 8'h93, "R9 two-port OR");
    for (int c = 0; c < NC; c++) if (c != 2) rd_chk(ack_a(c), 8'h00, "R9 other core untouched");
    req_chk("R9 req vector");

    // R7: set wins over same-cycle ack
    for (int i = 0; i < 16; i++) begin
      int c = i % NC;
      wr2(1, ring_a(c), 8'hFF, 0, '0, '0);
      wr2(1, ring_a(c), 8'(i*17), 1, ack_a(c), 8'(8'hF0 | i));
      rd_chk(ack_a(c), model[c], "R7 ring beats ack");
      req_chk("R7 req");
    end

    // R8: write sweep over every address
    clear_all();
    for (int a = 0; a < 256; a++) begin
      wr2(1, AW'(a), 8'hFF, 0, '0, '0);
      req_chk("R8 req after address sweep write");
      for (int c = 0; c < NC; c++) rd_chk(ack_a(c), model[c], "R8 word after address sweep write");
      if (model[0] | model[1] | model[2] | model[3]) clear_all();
    end

    // R5 / R4: read sweep with distinct contents
    for (int c = 0; c < NC; c++) wr2(1, ring_a(c), 8'(8'h11 * (c + 1)), 0, '0, '0);
    for (int a = 0; a < 256; a++) begin
      logic [BW-1:0] e;
      e = '0;
      for (int c = 0; c < NC; c++) if (AW'(a) == ack_a(c)) e = model[c];
      rd_chk(AW'(a), e, "R5 read sweep");
    end

    // R4: read and write on same edge returns the old word, then holds
    @(negedge clk);
    rd_en = 1; rd_addr = ack_a(3);
    wr_en = 2'b01; wr_addr[0] = ring_a(3); wr_data[0] = 8'h80;
    @(posedge clk); #1;
    rd_en = 0; wr_en = '0;
    chk(32'(rd_data), 32'h44, "R4 read sees pre-write value");
    model[3] = model[3] | 8'h80;
    repeat (3) @(posedge clk); #1;
    chk(32'(rd_data), 32'h44, "R4 rd_data holds without rd_en");
    rd_chk(ack_a(3), 8'hC4, "R4 next read sees update");

    finish_run();
  end
endmodule